// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into a serial bit stream on a single line. A character is offered with a valid/ready handshake. Once it is taken, the block waits for the next pulse of an external bit-rate enable and then shifts the frame out, one bit per enable period. The frame may be asynchronous, with a low start bit, the data bits least significant first, an optional extra bit and one or two high stop bits. It may instead be a bare synchronous run of data bits with no framing at all.

The extra bit after the data is either a parity bit of selectable sense or, in multiprocessor format, an ID/data marker taken from an input flag. Multiprocessor format overrides the parity settings. Synchronous mode overrides parity, stop length and multiprocessor format. The character length is the full data width or one bit shorter. All mode inputs are captured together with the character, so a change on them during a frame does not affect that frame.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset `txLine` is 1, `busy` is 0 and `inReady` is 1; whenever `busy` is 0 the line is held at 1.
- R2: A character is accepted on a rising clock edge where `inValid` and `inReady` are both 1. `busy` is 1 and `inReady` is 0 from the next cycle until the frame ends. A request held high while busy waits and is accepted once the block is idle again.
- R3: The first frame bit appears on the line at the first clock edge with `bitTick` high after acceptance. Each later bit replaces it at the next edge with `bitTick` high, and the line never changes on an edge without `bitTick`. One tick after the last bit, the line returns to 1 and `busy` falls.
- R4: An asynchronous frame consists of a 0 start bit, then the data bits least significant first, then stop bits at 1. With `cfgTwoStop`=0 there is exactly one stop bit.
- R5: With `cfgParityEn`=1 and `cfgParityOdd`=0, one bit follows the data, chosen so that the data bits plus this bit hold an even number of 1s.
- R6: With `cfgParityEn`=1 and `cfgParityOdd`=1, that bit makes the count of 1s odd.
- R7: With `cfgParityEn`=0 no bit is placed between data and stop, and `cfgParityOdd` has no effect on the line.
- R8: With `cfgTwoStop`=1 two stop bits at 1 follow the character.
- R9: With `cfgMultiProc`=1 the bit after the data equals `mpIdFlag` (1 marks an ID cycle, 0 a data cycle), and `cfgParityEn` and `cfgParityOdd` are ignored.
- R10: With `cfgSyncMode`=1 only the data bits are sent, with no start, parity, marker or stop bit, and the stop, parity and multiprocessor inputs are ignored.
- R11: With `cfgShortChar`=1 only the lower DATA_W-1 data bits are sent, and parity covers only those bits. With `cfgShortChar`=0, all DATA_W bits are sent.
- R12: Data and all mode inputs are sampled at acceptance; changing them while `busy` is 1 does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | DATA_W | Character to send |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Block can accept a character |
| bitTick | input | 1 | Bit-rate enable, one pulse per bit period |
| cfgParityEn | input | 1 | Append parity bit (asynchronous mode) |
| cfgParityOdd | input | 1 | 0 = even parity, 1 = odd parity |
| cfgTwoStop | input | 1 | 0 = one stop bit, 1 = two |
| cfgMultiProc | input | 1 | Send the ID/data marker in place of parity |
| cfgSyncMode | input | 1 | Send data bits only, no framing |
| cfgShortChar | input | 1 | Send DATA_W-1 data bits instead of DATA_W |
| mpIdFlag | input | 1 | Marker value in multiprocessor format |
| txLine | output | 1 | Serial output, idle high |
| busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with DATA_W = 8, so the short-character setting gives 7-bit characters and the longest frame is 12 bits. Both character lengths, every framing combination, and the counter and shift register at their full length are therefore covered. The bit-rate enable is run with periods of 1, 3 and 7 clocks. The period of 1 puts back-to-back ticks right at acceptance and at the end of a frame. The longer periods show that the line stays still between ticks.

// File: rtl/txfr_pkg.sv
package txfr_pkg;

  // Frame options captured with a character
  typedef struct packed {
    logic parityEn;
    logic parityOdd;
    logic twoStop;
    logic multiProc;
    logic syncMode;
    logic shortChar;
    logic mpId;
  } txMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture the composed frame
    logic shift;     // drive next frame bit onto the line
    logic endFrame;  // return the line to idle
  } txStrobe_t;

endpackage

// File: rtl/txfr_datapath.sv
module txfr_datapath
  import txfr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] charIn,
  input  txMode_t           mode,
  output logic [CNT_W-1:0]  frameLen,
  output logic              lineOut
);

  localparam int LONG_LEN  = DATA_W;
  localparam int SHORT_LEN = DATA_W - 1;

  logic [FRAME_W-1:0] dataExt;
  logic [FRAME_W-1:0] afterStart;
  logic [FRAME_W-1:0] frameBits;
  logic [FRAME_W-1:0] shiftReg;
  logic               parityBit;
  logic               hasExtra;
  logic               extraBit;
  int                 charLen;
  int                 asyncLen;

  // Character, zero-extended, top bit cleared in short mode
  always_comb begin
    dataExt = '0;
    dataExt[DATA_W-1:0] = charIn;
    if (mode.shortChar) begin
      dataExt[DATA_W-1] = 1'b0;
    end
    charLen = mode.shortChar ? SHORT_LEN : LONG_LEN;
  end

  // Extra bit after the data: marker overrides parity
  always_comb begin
    parityBit  = (^dataExt) ^ mode.parityOdd;
    hasExtra   = mode.multiProc | mode.parityEn;
    extraBit   = mode.multiProc ? mode.mpId : parityBit;
    afterStart = {dataExt[FRAME_W-2:0], 1'b0};
  end

  // Compose frame, bit 0 is sent first, unused tail stays at 1
  always_comb begin
    for (int i = 0; i < FRAME_W; i++) begin
      if (mode.syncMode) begin
        frameBits[i] = (i < charLen) ? dataExt[i] : 1'b1;
      end else if (i <= charLen) begin
        frameBits[i] = afterStart[i];
      end else if ((i == charLen + 1) && hasExtra) begin
        frameBits[i] = extraBit;
      end else begin
        frameBits[i] = 1'b1;
      end
    end
  end

  always_comb begin
    asyncLen = 1 + charLen + (hasExtra ? 1 : 0) + (mode.twoStop ? 2 : 1);
    frameLen = mode.syncMode ? CNT_W'(charLen) : CNT_W'(asyncLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
      lineOut  <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftReg <= frameBits;
      end else if (strobe.shift) begin
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      end
      if (strobe.shift) begin
        lineOut <= shiftReg[0];
      end else if (strobe.endFrame) begin
        lineOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/txfr_ctrl.sv
module txfr_ctrl
  import txfr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             bitTick,
  input  logic [CNT_W-1:0] frameLen,
  output logic             reqReady,
  output logic             busyOut,
  output txStrobe_t        strobe
);

  typedef enum logic {ST_IDLE, ST_RUN} txState_t;

  txState_t         state;
  logic [CNT_W-1:0] bitsLeft;
  logic             lastDone;

  always_comb begin
    lastDone        = (bitsLeft == '0);
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && reqValid;
    strobe.shift    = (state == ST_RUN) && bitTick && !lastDone;
    strobe.endFrame = (state == ST_RUN) && bitTick && lastDone;
    reqReady        = (state == ST_IDLE);
    busyOut         = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_RUN;
            bitsLeft <= frameLen;
          end
        end
        ST_RUN: begin
          if (bitTick) begin
            if (lastDone) begin
              state <= ST_IDLE;
            end else begin
              bitsLeft <= bitsLeft - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import txfr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              bitTick,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              cfgMultiProc,
  input  logic              cfgSyncMode,
  input  logic              cfgShortChar,
  input  logic              mpIdFlag,
  output logic              txLine,
  output logic              busy
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  txMode_t          modeNow;
  txStrobe_t        strobe;
  logic [CNT_W-1:0] frameLen;

  always_comb begin
    modeNow.parityEn  = cfgParityEn;
    modeNow.parityOdd = cfgParityOdd;
    modeNow.twoStop   = cfgTwoStop;
    modeNow.multiProc = cfgMultiProc;
    modeNow.syncMode  = cfgSyncMode;
    modeNow.shortChar = cfgShortChar;
    modeNow.mpId      = mpIdFlag;
  end

  txfr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (inValid),
    .bitTick  (bitTick),
    .frameLen (frameLen),
    .reqReady (inReady),
    .busyOut  (busy),
    .strobe   (strobe)
  );

  txfr_datapath #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .charIn   (inData),
    .mode     (modeNow),
    .frameLen (frameLen),
    .lineOut  (txLine)
  );

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic bitTick,
  input logic txLine,
  input logic busy
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);  // R1

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> busy);  // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !inReady);  // R2

  AST_LINE_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txLine));  // R3

  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(bitTick));  // R3

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .bitTick (bitTick),
  .txLine  (txLine),
  .busy    (busy)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic          bitTick = 1'b0;
  logic          cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic          cfgMultiProc = 1'b0, cfgSyncMode = 1'b0, cfgShortChar = 1'b0;
  logic          mpIdFlag = 1'b0;
  logic          txLine;
  logic          busy;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  int    tickDiv = 3;
  int    tickCnt = 0;

  bit mdlBusy = 1'b0;
  bit mdlLine = 1'b1;
  bit bitQ[$];

  always #4 clk = ~clk;  // 125 MHz

  serial_frame_tx #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .bitTick(bitTick), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop(cfgTwoStop), .cfgMultiProc(cfgMultiProc), .cfgSyncMode(cfgSyncMode),
    .cfgShortChar(cfgShortChar), .mpIdFlag(mpIdFlag), .txLine(txLine), .busy(busy)
  );

  // Expected bit sequence for one character, built from the requirements
  task automatic buildFrame();
    int n;
    int ones;
    bitQ.delete();
    n = cfgShortChar ? DW - 1 : DW;
    ones = 0;
    if (!cfgSyncMode) bitQ.push_back(1'b0);
    for (int k = 0; k < n; k++) begin
      bitQ.push_back(inData[k]);
      ones += int'(inData[k]);
    end
    if (!cfgSyncMode) begin
      if (cfgMultiProc) bitQ.push_back(mpIdFlag);
      else if (cfgParityEn) bitQ.push_back(bit'((ones + int'(cfgParityOdd)) % 2));
      bitQ.push_back(1'b1);
      if (cfgTwoStop) bitQ.push_back(1'b1);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mdlBusy = 1'b0;
      mdlLine = 1'b1;
      bitQ.delete();
    end else if (!mdlBusy) begin
      if (inValid) begin
        buildFrame();
        mdlBusy = 1'b1;
      end
    end else if (bitTick) begin
      if (bitQ.size() > 0) begin
        mdlLine = bitQ.pop_front();
      end else begin
        mdlLine = 1'b1;
        mdlBusy = 1'b0;
      end
    end
  end

  // Bit-rate enable and per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    tickCnt++;
    bitTick = ((tickCnt % tickDiv) == 0);
    if (rstN) begin
      checks++;
      if (txLine !== mdlLine) begin
        errors++;
        $display("FAIL %s: txLine got %b expected %b at %0t", curReq, txLine, mdlLine, $time);
      end
      checks++;
      if (busy !== mdlBusy) begin
        errors++;
        $display("FAIL R3: busy got %b expected %b at %0t", busy, mdlBusy, $time);
      end
      checks++;
      if (inReady !== !mdlBusy) begin
        errors++;
        $display("FAIL R2: inReady got %b expected %b at %0t", inReady, !mdlBusy, $time);
      end
    end
  end

  task automatic sendChar(input logic [DW-1:0] d, input bit pe, input bit po, input bit ts,
                          input bit mp, input bit sy, input bit sh, input bit id,
                          input bit scramble, input bit early, input string req);
    @(negedge clk);
    curReq = req;
    if (early) begin
      inData = d; cfgParityEn = pe; cfgParityOdd = po; cfgTwoStop = ts;
      cfgMultiProc = mp; cfgSyncMode = sy; cfgShortChar = sh; mpIdFlag = id;
      inValid = 1'b1;
    end
    while (!inReady) @(negedge clk);
    inData = d; cfgParityEn = pe; cfgParityOdd = po; cfgTwoStop = ts;
    cfgMultiProc = mp; cfgSyncMode = sy; cfgShortChar = sh; mpIdFlag = id;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checks++;
    if (!(busy === 1'b1 && inReady === 1'b0)) begin
      errors++;
      $display("FAIL R2: after accept busy=%b inReady=%b expected 1/0", busy, inReady);
    end
    if (scramble) begin
      inData = ~d; cfgParityEn = ~pe; cfgParityOdd = ~po; cfgTwoStop = ~ts;
      cfgMultiProc = ~mp; cfgSyncMode = ~sy; cfgShortChar = ~sh; mpIdFlag = ~id;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (4) @(negedge clk);
    checks++;
    if (!(txLine === 1'b1 && busy === 1'b0 && inReady === 1'b1)) begin
      errors++;
      $display("FAIL R1: reset line/busy/ready got %b%b%b expected 101", txLine, busy, inReady);
    end
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    //        data   pe po ts mp sy sh id scr early
    sendChar(8'hA5, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    sendChar(8'h3C, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    sendChar(8'hB7, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    sendChar(8'h01, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    sendChar(8'hB7, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    sendChar(8'h00, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    sendChar(8'h5A, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R7");
    sendChar(8'hFF, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
    sendChar(8'h6D, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R8");
    sendChar(8'h42, 1, 1, 0, 1, 0, 0, 1, 0, 0, "R9");
    sendChar(8'h81, 1, 0, 1, 1, 0, 0, 0, 0, 0, "R9");
    sendChar(8'h96, 1, 1, 1, 1, 1, 0, 1, 0, 0, "R10");
    sendChar(8'h2B, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R10");
    sendChar(8'h80, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R11");
    sendChar(8'hFF, 1, 1, 0, 0, 0, 1, 0, 0, 0, "R11");
    sendChar(8'hC3, 1, 0, 1, 0, 0, 0, 0, 1, 0, "R12");
    sendChar(8'h17, 0, 0, 0, 1, 0, 1, 1, 1, 0, "R12");
    tickDiv = 1;
    sendChar(8'h4E, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R3");
    sendChar(8'h99, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R2");
    sendChar(8'h99, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    tickDiv = 7;
    sendChar(8'hE1, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R3");
    sendChar(8'h3F, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule